// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit sequences the memory side of a multi-register load or store. A single start strobe hands it a 16-bit register selection mask, a 32-bit base address, a two-bit addressing mode, a writeback enable, a load/store flag and a user-bank flag. It counts the selected registers and works out the lowest address the transfer touches. Then it issues one word request per accepted handshake. Each request carries a byte address, the register index and a flag that marks the final transfer.

Whatever the direction of the mode, registers are always visited from the lowest index to the highest, starting from the lowest address. The address rises by one word per transfer. At the end the unit reports the base value to be written back, and it pulses a done strobe. It also raises flags that tell the surrounding core two things: that the program counter is among the loaded registers, and whether the status word must be restored or user-bank registers used. The register file, the data path and bank switching stay outside.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, and until a start strobe arrives while the unit is not busy, `req_valid`, `done` and `busy` are low. A start strobe seen while `busy` is high has no effect on the operation in progress.
- R2: An operation issues exactly as many requests as there are set bits in `reg_list`.
- R3: Requests carry register indices in strictly ascending order, and each index is one whose bit is set in `reg_list`.
- R4: The address of the first request depends on `mode`. For 0 (increment, after) it is the base. For 1 (increment, before) it is the base + 4. For 2 (decrement, after) it is the base − 4·N + 4. For 3 (decrement, before) it is the base − 4·N. N is the number of set bits, and arithmetic wraps at 32 bits.
- R5: Each later request has the address of the previous one + 4.
- R6: While `req_valid` is high and `req_ready` is low, the request's address, index and last flag stay unchanged.
- R7: `req_last` is high only on the final request. `done` is high for exactly one cycle, which is the cycle after the final request is accepted.
- R8: When `done` is high, `base_out` equals base + 4·N for modes 0 and 1, and base − 4·N for modes 2 and 3, if `wb_en` was set. Otherwise it equals the base.
- R9: An empty `reg_list` raises `done` in the cycle after start, issues no request, and leaves `base_out` equal to the base.
- R10: `pc_load` is high from the cycle after start through `done` exactly when `is_load` is set and bit 15 of `reg_list` is set.
- R11: `restore_status` is high when `s_bit`, `is_load` and `reg_list[15]` are all set. `req_user_bank` is high when `s_bit` is set and that load-with-bit-15 case does not apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| reg_list | input | 16 | Register selection mask, bit i selects register i |
| base_addr | input | 32 | Base address |
| mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wb_en | input | 1 | Report the updated base on `base_out` |
| is_load | input | 1 | 1 for load, 0 for store |
| s_bit | input | 1 | User-bank / status-restore request |
| busy | output | 1 | Operation in progress, including the done cycle |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by memory side |
| req_addr | output | 32 | Word byte address of the request |
| req_idx | output | 4 | Register index of the request |
| req_last | output | 1 | Final request of the operation |
| req_user_bank | output | 1 | Request uses the user-mode register bank |
| done | output | 1 | One-cycle completion pulse |
| base_out | output | 32 | Base value to write back |
| pc_load | output | 1 | Program counter is among the loaded registers |
| restore_status | output | 1 | Saved status word must be copied to the current one |

## Verification
The hardest situations to reach are the stalls: a request held by low `req_ready` on the final transfer, and a second start strobe arriving in the middle of an operation. Both must leave the sequence untouched. The bench drives `req_ready` low at random on about a quarter of cycles, so stalls land on first, middle and last requests alike. It can also inject a start strobe with the complemented mask while the first request is pending. Directed masks cover the empty list, a lone bit 15 with the user-bank flag, the full mask, and a decrement below address zero that wraps.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } am_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } st_e;
endpackage

// File: rtl/bxs_popcnt.sv
module bxs_popcnt #(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/bxs_lowest.sv
module bxs_lowest #(
  parameter int W  = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found,
  output logic [W-1:0]  rest,
  output logic          single
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    found  = |vec;
    rest   = vec & (vec - W'(1));
    single = found && (rest == '0);
  end
endmodule

// File: rtl/bxs_addr_calc.sv
module bxs_addr_calc
  import bxs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 5,
  parameter int STEP = 4
) (
  input  am_e           mode,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  output logic [AW-1:0] first,
  output logic [AW-1:0] final_base
);
  logic [AW-1:0] span;

  always_comb begin
    span = AW'(cnt) * AW'(STEP);
    unique case (mode)
      AM_INC_AFTER:  first = base;
      AM_INC_BEFORE: first = base + AW'(STEP);
      AM_DEC_AFTER:  first = base - span + AW'(STEP);
      default:       first = base - span;
    endcase
    final_base = mode[1] ? (base - span) : (base + span);
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bxs_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int ADDR_W = 32,
  parameter int STEP   = 4,
  localparam int CW    = $clog2(LIST_W + 1),
  localparam int IW    = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LIST_W-1:0] reg_list,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [1:0]        mode,
  input  logic              wb_en,
  input  logic              is_load,
  input  logic              s_bit,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [IW-1:0]     req_idx,
  output logic              req_last,
  output logic              req_user_bank,
  output logic              done,
  output logic [ADDR_W-1:0] base_out,
  output logic              pc_load,
  output logic              restore_status
);
  st_e               st_q;
  logic [LIST_W-1:0] rem_q;
  logic [LIST_W-1:0] pick_in, pick_rest;
  logic [IW-1:0]     pick_idx;
  logic              pick_found, pick_single;
  logic [CW-1:0]     sel_cnt;
  logic [ADDR_W-1:0] first_addr, wb_addr;
  logic              ld_pc;

  assign pick_in = (st_q == ST_IDLE) ? reg_list : rem_q;
  assign ld_pc   = is_load & reg_list[LIST_W-1];

  bxs_popcnt #(.W(LIST_W)) u_cnt (.vec(reg_list), .cnt(sel_cnt));

  bxs_lowest #(.W(LIST_W)) u_pick (
    .vec(pick_in), .idx(pick_idx), .found(pick_found),
    .rest(pick_rest), .single(pick_single)
  );

  bxs_addr_calc #(.AW(ADDR_W), .CW(CW), .STEP(STEP)) u_addr (
    .mode(am_e'(mode)), .base(base_addr), .cnt(sel_cnt),
    .first(first_addr), .final_base(wb_addr)
  );

  assign busy = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      rem_q          <= '0;
      req_valid      <= 1'b0;
      req_addr       <= '0;
      req_idx        <= '0;
      req_last       <= 1'b0;
      req_user_bank  <= 1'b0;
      done           <= 1'b0;
      base_out       <= '0;
      pc_load        <= 1'b0;
      restore_status <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          done <= 1'b0;
          if (start) begin
            pc_load        <= ld_pc;
            restore_status <= ld_pc & s_bit;
            req_user_bank  <= s_bit & ~ld_pc;
            base_out       <= wb_en ? wb_addr : base_addr;
            if (pick_found) begin
              st_q      <= ST_XFER;
              req_valid <= 1'b1;
              req_addr  <= first_addr;
              req_idx   <= pick_idx;
              req_last  <= pick_single;
              rem_q     <= pick_rest;
            end else begin
              st_q <= ST_DONE;
              done <= 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (req_ready) begin
            if (req_last) begin
              req_valid <= 1'b0;
              req_last  <= 1'b0;
              st_q      <= ST_DONE;
              done      <= 1'b1;
            end else begin
              req_addr <= req_addr + ADDR_W'(STEP);
              req_idx  <= pick_idx;
              req_last <= pick_single;
              rem_q    <= pick_rest;
            end
          end
        end
        default: begin
          done <= 1'b0;
          st_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bxs_chk.sv
module bxs_chk #(
  parameter int LIST_W = 16,
  parameter int ADDR_W = 32,
  parameter int STEP   = 4,
  localparam int IW    = $clog2(LIST_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [IW-1:0]     req_idx,
  input logic              req_last,
  input logic              req_user_bank,
  input logic              done,
  input logic              pc_load,
  input logic              restore_status
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!req_valid && !done));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_idx) && $stable(req_last)));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_last) |=> (req_valid && req_addr == $past(req_addr) + ADDR_W'(STEP)));

  p_idx_up_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_last) |=> (req_idx > $past(req_idx)));

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_last) |=> (done && !req_valid));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_restore_implies_pc_r11: assert property (@(posedge clk) disable iff (rst)
    restore_status |-> pc_load);

  p_user_excl_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user_bank) |-> !restore_status);
endmodule

bind blk_xfer_seq bxs_chk #(.LIST_W(LIST_W), .ADDR_W(ADDR_W), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_idx(req_idx), .req_last(req_last),
  .req_user_bank(req_user_bank), .done(done), .pc_load(pc_load),
  .restore_status(restore_status)
);

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] reg_list = '0;
  logic [31:0] base_addr = '0;
  logic [1:0]  mode = '0;
  logic        wb_en = 1'b0, is_load = 1'b0, s_bit = 1'b0;
  logic        busy, req_valid, req_last, req_user_bank, done, pc_load, restore_status;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr, base_out;
  logic [3:0]  req_idx;

  int vecs = 0;
  int fails = 0;

  always #2 clk = ~clk;

  blk_xfer_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .reg_list(reg_list), .base_addr(base_addr),
    .mode(mode), .wb_en(wb_en), .is_load(is_load), .s_bit(s_bit), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_idx(req_idx),
    .req_last(req_last), .req_user_bank(req_user_bank), .done(done), .base_out(base_out),
    .pc_load(pc_load), .restore_status(restore_status)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] lst, input logic [31:0] base, input logic [1:0] md,
                        input bit wb, input bit ld, input bit s, input bit poke);
    int          idxq[$];
    int          n;
    logic [31:0] span, first, wbv;
    bit          pc_e, rs_e, ub_e;
    for (int i = 0; i < 16; i++) if (lst[i]) idxq.push_back(i);
    n    = idxq.size();
    span = 32'(n) * 32'd4;
    case (md)
      2'd0: first = base;
      2'd1: first = base + 32'd4;
      2'd2: first = base - span + 32'd4;
      default: first = base - span;
    endcase
    wbv  = wb ? ((md >= 2'd2) ? base - span : base + span) : base;
    pc_e = ld && lst[15];
    rs_e = s && pc_e;
    ub_e = s && !pc_e;

    @(negedge clk);
    start = 1'b1; reg_list = lst; base_addr = base; mode = md;
    wb_en = wb; is_load = ld; s_bit = s;

    if (n == 0) begin
      @(negedge clk);
      start = 1'b0;
      chk("R9 done after empty start", 32'(done), 32'd1);
      chk("R9 no request", 32'(req_valid), 32'd0);
      chk("R9 base unchanged", base_out, base);
      @(negedge clk);
      chk("R7 done single cycle", 32'(done), 32'd0);
      chk("R1 idle after done", 32'(busy), 32'd0);
      return;
    end

    for (int k = 0; k < n; k++) begin
      bit rdy = 1'b0;
      bit poked = 1'b0;
      while (!rdy) begin
        @(negedge clk);
        start = 1'b0;
        chk("R2 request valid", 32'(req_valid), 32'd1);
        chk(k == 0 ? "R4 first address" : "R5 address step", req_addr, first + 32'(k) * 32'd4);
        chk("R3 register index", 32'(req_idx), 32'(idxq[k]));
        chk("R7 last flag", 32'(req_last), 32'(k == n - 1));
        chk("R7 no early done", 32'(done), 32'd0);
        chk("R10 pc load flag", 32'(pc_load), 32'(pc_e));
        chk("R11 restore status", 32'(restore_status), 32'(rs_e));
        chk("R11 user bank", 32'(req_user_bank), 32'(ub_e));
        if (poke && k == 0 && !poked) begin
          start = 1'b1; reg_list = ~lst; poked = 1'b1;
        end
        rdy = (($urandom % 4) != 0);
        req_ready = rdy;
      end
    end
    @(negedge clk);
    start = 1'b0; req_ready = 1'b0;
    chk("R7 done after last", 32'(done), 32'd1);
    chk("R2 no extra request", 32'(req_valid), 32'd0);
    chk("R8 written-back base", base_out, wbv);
    chk("R10 pc load at done", 32'(pc_load), 32'(pc_e));
    @(negedge clk);
    chk("R7 done single cycle", 32'(done), 32'd0);
    chk("R1 idle after done", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R1 reset valid low", 32'(req_valid), 32'd0);
      chk("R1 reset done low", 32'(done), 32'd0);
      chk("R1 reset busy low", 32'(busy), 32'd0);
    end
    run_op(16'h0000, 32'h0000_1000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op(16'h0000, 32'h0000_2000, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    run_op(16'h8000, 32'h0000_0100, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
    run_op(16'h8000, 32'h0000_0100, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op(16'hFFFF, 32'h0000_4000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1);
    run_op(16'h0001, 32'h0000_0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    run_op(16'h00F0, 32'h0000_0008, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    run_op(16'h8001, 32'hFFFF_FFF8, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int t = 0; t < 200; t++) begin
      run_op(16'($urandom), {$urandom} & 32'hFFFF_FFFC, 2'(t % 4),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule